// File: doc/BRIEF.md
# Retrace-Synchronised Keyboard Indicator Latch

This block drives twelve keyboard indicator lamps from bits that software keeps in display memory. It watches the write traffic to that memory and keeps a private copy of the two words that carry indicator state. The first word is a dedicated indicator byte that supplies eight lamps. The second is the display status byte, which also holds the video-mode and cursor-style fields. Only its upper nibble belongs to the indicators and supplies the other four lamps.

The lamps never follow those copies directly. A twelve-bit output latch is reloaded exactly once per frame, on the rising edge of the vertical retrace signal. Indicator changes therefore become visible only between frames, and a lamp is lit whenever its latch bit holds 1. Software may rewrite either byte at any time. The lamps show the values that were held at the start of the next retrace.

Top module: `kbd_led_latch`

## Requirements
- R1: While reset is asserted, all twelve outputs are 0. The captured copies are also cleared, so a retrace with no prior write leaves every lamp dark.
- R2: A write to the indicator byte address (default 14'h3FF3) is captured. At the next retrace rise, output bit k (k = 0..7) takes bit k of that byte.
- R3: A write to the status byte address (default 14'h3FF2) captures data bits 7..4. At the next retrace rise, those bits drive outputs 11..8, with data bit 4 on output 8 and data bit 7 on output 11.
- R4: Bits 3..0 of a status byte write (the video and cursor fields) have no effect on any output.
- R5: The outputs change only in the clock cycle after a retrace rise is seen. Writes made while retrace is low leave them unchanged.
- R6: One retrace pulse causes one load. Writes made while retrace stays high are not shown until the following rising edge.
- R7: Writes to any other address, or cycles with the write enable low, leave both captured bytes and the outputs unchanged.
- R8: A write in the same clock cycle as the retrace rise is not shown by that load. It appears at the next rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vretrace | input | 1 | Vertical retrace, high during the blanking interval |
| wr_en | input | 1 | Display memory write strobe |
| wr_addr | input | ADDR_W (14) | Display memory write address |
| wr_data | input | 8 | Display memory write data |
| led | output | 12 | Lamp drive, 1 = lit; bits 7..0 come from the indicator byte, bits 11..8 from status bits 7..4 |

## Verification
The main sweep writes all 256 indicator byte values. Each one is paired with a status value that rotates through every upper nibble, and the lower nibble is varied at the same time. The outputs are checked once mid-frame, where they must hold the previous frame's value, and once after a retrace pulse. This separates a latch that loads early from one that loads late, and a wrong bit order from a wrong address decode. Targeted patterns separate the remaining cases:
- A write of only the status low nibble, which must change nothing.
- Writes to neighbouring addresses and strobe-less cycles, which must be ignored.
- Writes during a long retrace, which must wait for the next rising edge.
- A write in the same cycle as the rising edge, which must be deferred to the following frame.

// File: rtl/kbd_led_pkg.sv
package kbd_led_pkg;
  localparam int LED_BYTE_W = 8;
  localparam int STAT_NIB_W = 4;
  localparam int LED_TOTAL  = LED_BYTE_W + STAT_NIB_W;
  localparam int STAT_NIB_LSB = 4;

  // Lamp word: status nibble above, dedicated byte below.
  function automatic logic [LED_TOTAL-1:0] led_merge(
    input logic [STAT_NIB_W-1:0] nib,
    input logic [LED_BYTE_W-1:0] byte_in
  );
    return {nib, byte_in};
  endfunction

  function automatic logic [STAT_NIB_W-1:0] status_lamps(input logic [7:0] status_byte);
    return status_byte[STAT_NIB_LSB +: STAT_NIB_W];
  endfunction
endpackage

// File: rtl/kbd_led_shadow.sv
module kbd_led_shadow
  import kbd_led_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 14'h3FF2,
  parameter logic [ADDR_W-1:0] LAMP_ADDR   = 14'h3FF3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [7:0]            wr_data,
  output logic                  hit_status,
  output logic                  hit_lamp,
  output logic [STAT_NIB_W-1:0] stat_nib_q,
  output logic [LED_BYTE_W-1:0] lamp_byte_q
);
  assign hit_status = wr_en && (wr_addr == STATUS_ADDR);
  assign hit_lamp   = wr_en && (wr_addr == LAMP_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_nib_q  <= '0;
      lamp_byte_q <= '0;
    end else begin
      if (hit_status) stat_nib_q  <= status_lamps(wr_data);
      if (hit_lamp)   lamp_byte_q <= wr_data;
    end
  end

  // R7: foreign addresses and idle cycles leave both copies alone
  p_foreign_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_status && !hit_lamp) |=> ($stable(stat_nib_q) && $stable(lamp_byte_q)));

  // R3: status capture takes the upper data nibble
  p_status_nibble_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_status |=> (stat_nib_q == $past(wr_data[7:4])));

  // R2: dedicated byte captured whole
  p_lamp_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_lamp |=> (lamp_byte_q == $past(wr_data)));
endmodule

// File: rtl/kbd_led_vedge.sv
module kbd_led_vedge (
  input  logic clk,
  input  logic rst_n,
  input  logic vretrace,
  output logic rise
);
  logic vr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) vr_q <= 1'b0;
    else        vr_q <= vretrace;
  end

  assign rise = vretrace && !vr_q;

  // R6: a rising edge is never reported on two consecutive cycles
  p_single_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/kbd_led_outlatch.sv
module kbd_led_outlatch #(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] next_word,
  output logic [WIDTH-1:0] led_q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)    led_q[i] <= 1'b0;
      else if (load) led_q[i] <= next_word[i];
    end
  end

  // R5: outputs hold whenever no load is requested
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(led_q));

  // R2: a load presents the captured word
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (led_q == $past(next_word)));
endmodule

// File: rtl/kbd_led_latch.sv
module kbd_led_latch
  import kbd_led_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 14'h3FF2,
  parameter logic [ADDR_W-1:0] LAMP_ADDR   = 14'h3FF3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 vretrace,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [7:0]           wr_data,
  output logic [LED_TOTAL-1:0] led
);
  logic                  hit_status;
  logic                  hit_lamp;
  logic [STAT_NIB_W-1:0] stat_nib_q;
  logic [LED_BYTE_W-1:0] lamp_byte_q;
  logic                  retrace_rise;
  logic [LED_TOTAL-1:0]  shadow_word;

  kbd_led_shadow #(
    .ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR), .LAMP_ADDR(LAMP_ADDR)
  ) u_shadow (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .hit_status(hit_status), .hit_lamp(hit_lamp),
    .stat_nib_q(stat_nib_q), .lamp_byte_q(lamp_byte_q)
  );

  kbd_led_vedge u_vedge (
    .clk(clk), .rst_n(rst_n), .vretrace(vretrace), .rise(retrace_rise)
  );

  assign shadow_word = led_merge(stat_nib_q, lamp_byte_q);

  kbd_led_outlatch #(.WIDTH(LED_TOTAL)) u_out (
    .clk(clk), .rst_n(rst_n), .load(retrace_rise),
    .next_word(shadow_word), .led_q(led)
  );

  // R5: with retrace low throughout, the lamps cannot move
  p_midframe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !vretrace |=> $stable(led));

  // R8: a write coinciding with the load is not shown by it
  p_same_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (retrace_rise && hit_lamp) |=> (led[LED_BYTE_W-1:0] == $past(lamp_byte_q)));
endmodule

// File: tb/sim_kbd_led_latch.sv
module sim_kbd_led_latch;
  localparam logic [13:0] A_STAT = 14'h3FF2;
  localparam logic [13:0] A_LAMP = 14'h3FF3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vretrace = 1'b0;
  logic        wr_en = 1'b0;
  logic [13:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [11:0] led;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [7:0]  m_lamp = '0;
  logic [3:0]  m_nib = '0;
  logic [11:0] m_led = '0;

  kbd_led_latch u0 (
    .clk(clk), .rst_n(rst_n), .vretrace(vretrace), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .led(led)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [11:0] exp);
    checks++;
    if (led !== exp) begin
      failures++;
      $display("FAIL %s led=%03h expected=%03h", req, led, exp);
    end
  endtask

  task automatic write(input logic [13:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == A_LAMP) m_lamp = d;
    if (a == A_STAT) m_nib = d[7:4];
  endtask

  task automatic pulse(input int high_cycles);
    @(negedge clk);
    vretrace = 1'b1;
    repeat (high_cycles) @(negedge clk);
    vretrace = 1'b0;
    m_led = {m_nib, m_lamp};
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 12'h000);
    rst_n = 1'b1;
    pulse(2);
    @(negedge clk);
    check("R1", 12'h000);

    // Main sweep: all indicator byte values, all status nibbles
    for (int v = 0; v < 256; v++) begin
      logic [7:0] s;
      s = 8'((v * 37 + 11) & 8'hFF);
      write(A_LAMP, 8'(v));
      write(A_STAT, s);
      check("R5", m_led);
      pulse(3);
      check((v % 2 == 0) ? "R2" : "R3", m_led);
    end

    // R4: low nibble of status has no effect
    write(A_STAT, 8'h50);
    pulse(1);
    @(negedge clk);
    check("R3", m_led);
    write(A_STAT, 8'h5F);
    pulse(1);
    @(negedge clk);
    check("R4", {4'h5, m_lamp});

    // R7: neighbouring addresses and strobe-less cycles
    write(14'h3FF1, 8'hFF);
    write(14'h3FF4, 8'h00);
    write(14'h1FF3, 8'hAA);
    @(negedge clk);
    wr_addr = A_LAMP; wr_data = 8'h77;
    @(negedge clk);
    pulse(1);
    @(negedge clk);
    check("R7", m_led);

    // R6: writes while retrace stays high wait for next rise
    @(negedge clk);
    vretrace = 1'b1;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = A_LAMP; wr_data = 8'h3C;
    @(negedge clk);
    wr_en = 1'b0;
    repeat (4) @(negedge clk);
    check("R6", m_led);
    vretrace = 1'b0;
    m_lamp = 8'h3C;
    @(negedge clk);
    check("R6", m_led);
    pulse(1);
    @(negedge clk);
    check("R6", m_led);

    // R8: write coinciding with the rising edge
    @(negedge clk);
    vretrace = 1'b1;
    wr_en = 1'b1; wr_addr = A_LAMP; wr_data = 8'hC3;
    @(negedge clk);
    wr_en = 1'b0;
    check("R8", m_led);
    vretrace = 1'b0;
    m_lamp = 8'hC3;
    pulse(1);
    @(negedge clk);
    check("R8", m_led);

    // R1: reset mid-operation clears lamps and copies
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", 12'h000);
    rst_n = 1'b1;
    pulse(1);
    @(negedge clk);
    check("R1", 12'h000);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule